// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the receive and reply front end of an on-chip debug link that runs over a two-wire asynchronous serial line. Each character is framed as 8N1: one low start bit, eight data bits sent least significant bit first, no parity, and one high stop bit. The block turns a header character into a one-cycle command strobe. The strobe carries a write flag, a byte/word flag and a 6-bit register address. For a write, the block then collects one or two data characters and presents them as a single data word. For a read, it takes a data word from the debug registers behind it and shifts that word back out on its transmit line.

The bit period is either learned or fixed. In learned mode, the first character after reset must be the synchronization character 0x80. That character holds the line low for exactly eight bit periods: the start bit plus seven zero data bits. The block counts the clock cycles of that low stretch, divides the count by eight, and keeps the result as the bit period for both directions. In fixed mode, the bit period is taken from a parameter holding clock/baud − 1, and the port is usable straight after reset. The receive line enters through a chain of flip-flops whose length is a parameter and may be zero.

The command state machine has seven states:

- **SYNC**: waits until a bit period is known, then moves to HDR.
- **HDR**: decodes a header character.
  - A write header moves to WLO.
  - A read header moves to RCAP.
- **WLO**: takes the first write character.
  - In byte mode it returns to HDR.
  - In word mode it moves to WHI.
- **WHI**: takes the high write character, then returns to HDR.
- **RCAP**: captures the read word and starts transmission of its low byte, then moves to TLO.
- **TLO**: waits for the low byte to finish.
  - In byte mode it returns to HDR.
  - In word mode it starts the high byte and moves to THI.
- **THI**: waits for the high byte to finish, then returns to HDR.

Characters that arrive during RCAP, TLO or THI are dropped.

Top module: `sdbg_port`

## Requirements
- R1: While reset is held and just after it is released, `cmd_valid` and `wr_valid` are low and `txd` is high. In learned mode, `baud_locked` is also low.
- R2: In learned mode, the first character after reset sets the bit period to its low time divided by eight, and `baud_locked` then rises and stays high. While `baud_locked` is low, no command is issued and `txd` stays high.
- R3: With `AUTO_SYNC`=0, `baud_locked` is high from reset, no synchronization character is needed, and the bit period is `FIXED_DIV`+1 clock cycles.
- R4: Characters are received as 8N1, least significant bit first. The start bit and each data bit are sampled near the middle of the bit, half a period after the falling edge of the start bit.
- R5: In a header character, bit 7 is the write flag (1 means write), bit 6 is the byte flag (1 means one data byte, 0 means a 16-bit word), and bits 5:0 are the address. `cmd_valid` pulses for exactly one cycle, before the header's stop bit ends, and the header fields are held until the next header arrives. `cmd_valid` and `wr_valid` are never high in the same cycle.
- R6: A word write takes two characters, low byte first. It produces exactly one one-cycle `wr_valid` pulse, with both bytes joined in `wr_data`.
- R7: A byte write takes one character. It produces one `wr_valid` pulse with `wr_data` = {8'h00, byte}.
- R8: A word read samples `rd_data` during the cycle in which `cmd_valid` is high. It then transmits `rd_data[7:0]` followed by `rd_data[15:8]` as 8N1 characters at the current bit period.
- R9: A byte read transmits only `rd_data[7:0]`, and `txd` then stays high.
- R10: A character whose stop bit is sampled low is discarded with no effect. The next well-formed character is accepted as normal.
- R11: `SYNC_STAGES` sets how many flip-flops the receive line passes through before it is used. With 0 the line is used directly, and the port still works.
- R12: A low pulse on `rxd` that is shorter than half a bit period is rejected as a false start and produces no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| baud_locked | output | 1 | A bit period is known |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_write | output | 1 | Command is a write |
| cmd_byte | output | 1 | Command carries one byte (otherwise a 16-bit word) |
| cmd_addr | output | 6 | Debug register address |
| wr_valid | output | 1 | One-cycle write data strobe |
| wr_data | output | 16 | Write data |
| rd_data | input | 16 | Read data, sampled while `cmd_valid` is high on a read |

## Verification
A received character reaches the command logic at the middle of its stop bit, after the synchronizer delay. `cmd_valid` or `wr_valid` then follows about SYNC_STAGES+2 cycles later, which is well inside the second half of the stop bit. For that reason, the bench counts strobes in a negative-edge monitor and compares the counts only after it has driven the whole stop bit. Transmission starts two cycles after a read `cmd_valid`, which is while the bench is still driving the header's stop bit. The bench therefore runs its serial receiver in parallel with the sender. That receiver finds each start bit on its own and samples every bit at mid-period, so the checks do not depend on a fixed cycle offset.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;
    typedef enum logic [2:0] {
        RX_MHUNT, RX_MLOW, RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        CS_SYNC, CS_HDR, CS_WLO, CS_WHI, CS_RCAP, CS_TLO, CS_THI
    } cmd_state_t;

    localparam int HDR_WR_BIT = 7;
    localparam int HDR_BW_BIT = 6;
    localparam int ADDR_W     = 6;
    localparam int SYNC_ZEROS_LOG2 = 3; // low time of the sync char spans 8 bits
endpackage

// File: rtl/sdbg_sync.sv
module sdbg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r <= '1;
                end else begin
                    r[0] <= din;
                    for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
                end
            end
            assign dout = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sdbg_rx.sv
module sdbg_rx import sdbg_pkg::*; #(
    parameter int CNT_W     = 16,
    parameter bit AUTO_SYNC = 1'b1,
    parameter int FIXED_DIV = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    output logic             byte_vld,
    output logic [7:0]       byte_out,
    output logic [CNT_W-1:0] bit_len,
    output logic             locked
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] FIX_LEN = CNT_W'(FIXED_DIV + 1);

    rx_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic [7:0]       sh;
    logic [2:0]       nbit;
    logic             rx_q;

    assign half = bit_len >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= AUTO_SYNC ? RX_MHUNT : RX_IDLE;
            cnt      <= '0;
            bit_len  <= FIX_LEN;
            locked   <= !AUTO_SYNC;
            sh       <= '0;
            nbit     <= '0;
            rx_q     <= 1'b1;
            byte_vld <= 1'b0;
            byte_out <= '0;
        end else begin
            rx_q     <= rx;
            byte_vld <= 1'b0;
            unique case (st)
                RX_MHUNT: if (!rx) begin
                    cnt <= ONE;
                    st  <= RX_MLOW;
                end
                RX_MLOW: if (!rx) begin
                    if (cnt != '1) cnt <= cnt + ONE;
                end else begin
                    bit_len <= cnt >> SYNC_ZEROS_LOG2;
                    locked  <= 1'b1;
                    st      <= RX_IDLE;
                end
                RX_IDLE: if (!rx && rx_q) begin
                    cnt <= '0;
                    st  <= RX_START;
                end
                RX_START: if (cnt == half) begin
                    cnt  <= '0;
                    nbit <= '0;
                    st   <= rx ? RX_IDLE : RX_DATA;
                end else begin
                    cnt <= cnt + ONE;
                end
                RX_DATA: if (cnt == bit_len - ONE) begin
                    cnt <= '0;
                    sh  <= {rx, sh[7:1]};
                    if (nbit == 3'd7) st <= RX_STOP;
                    else              nbit <= nbit + 3'd1;
                end else begin
                    cnt <= cnt + ONE;
                end
                RX_STOP: if (cnt == bit_len - ONE) begin
                    cnt <= '0;
                    st  <= RX_IDLE;
                    if (rx) begin
                        byte_vld <= 1'b1;
                        byte_out <= sh;
                    end
                end else begin
                    cnt <= cnt + ONE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sdbg_tx.sv
module sdbg_tx #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] bit_len,
    input  logic             go,
    input  logic [7:0]       din,
    output logic             txd,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam int FRAME_BITS = 10;

    logic [FRAME_BITS-1:0] sh;
    logic [CNT_W-1:0]      cnt;
    logic [3:0]            nbit;
    logic                  busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '1;
            cnt  <= '0;
            nbit <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    sh   <= {1'b1, din, 1'b0};
                    cnt  <= '0;
                    nbit <= '0;
                    busy <= 1'b1;
                end
            end else if (cnt == bit_len - ONE) begin
                cnt <= '0;
                sh  <= {1'b1, sh[FRAME_BITS-1:1]};
                if (nbit == 4'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    nbit <= nbit + 4'd1;
                end
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    assign txd = sh[0];
endmodule

// File: rtl/sdbg_port.sv
module sdbg_port import sdbg_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter bit AUTO_SYNC   = 1'b1,
    parameter int FIXED_DIV   = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    output logic              txd,
    output logic              baud_locked,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic              cmd_byte,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_valid,
    output logic [15:0]       wr_data,
    input  logic [15:0]       rd_data
);
    logic             rx_s;
    logic             rx_vld;
    logic [7:0]       rx_byte;
    logic [CNT_W-1:0] bit_len;
    logic             tx_go;
    logic             tx_done;
    logic [7:0]       tx_byte;
    logic [7:0]       wr_lo;
    logic [7:0]       rd_hi;

    cmd_state_t st, st_nx;

    sdbg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    sdbg_rx #(.CNT_W(CNT_W), .AUTO_SYNC(AUTO_SYNC), .FIXED_DIV(FIXED_DIV)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx(rx_s), .byte_vld(rx_vld),
        .byte_out(rx_byte), .bit_len(bit_len), .locked(baud_locked)
    );

    sdbg_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_len(bit_len), .go(tx_go),
        .din(tx_byte), .txd(txd), .done(tx_done)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            CS_SYNC: if (baud_locked) st_nx = CS_HDR;
            CS_HDR:  if (rx_vld) st_nx = rx_byte[HDR_WR_BIT] ? CS_WLO : CS_RCAP;
            CS_WLO:  if (rx_vld) st_nx = cmd_byte ? CS_HDR : CS_WHI;
            CS_WHI:  if (rx_vld) st_nx = CS_HDR;
            CS_RCAP: st_nx = CS_TLO;
            CS_TLO:  if (tx_done) st_nx = cmd_byte ? CS_HDR : CS_THI;
            CS_THI:  if (tx_done) st_nx = CS_HDR;
            default: st_nx = CS_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CS_SYNC;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_write <= 1'b0;
            cmd_byte  <= 1'b0;
            cmd_addr  <= '0;
            wr_valid  <= 1'b0;
            wr_data   <= '0;
            wr_lo     <= '0;
            rd_hi     <= '0;
            tx_go     <= 1'b0;
            tx_byte   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            wr_valid  <= 1'b0;
            tx_go     <= 1'b0;
            unique case (st)
                CS_HDR: if (rx_vld) begin
                    cmd_valid <= 1'b1;
                    cmd_write <= rx_byte[HDR_WR_BIT];
                    cmd_byte  <= rx_byte[HDR_BW_BIT];
                    cmd_addr  <= rx_byte[ADDR_W-1:0];
                end
                CS_WLO: if (rx_vld) begin
                    if (cmd_byte) begin
                        wr_valid <= 1'b1;
                        wr_data  <= {8'h00, rx_byte};
                    end else begin
                        wr_lo <= rx_byte;
                    end
                end
                CS_WHI: if (rx_vld) begin
                    wr_valid <= 1'b1;
                    wr_data  <= {rx_byte, wr_lo};
                end
                CS_RCAP: begin
                    tx_go   <= 1'b1;
                    tx_byte <= rd_data[7:0];
                    rd_hi   <= rd_data[15:8];
                end
                CS_TLO: if (tx_done && !cmd_byte) begin
                    tx_go   <= 1'b1;
                    tx_byte <= rd_hi;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdbg_port_chk.sv
module sdbg_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       baud_locked,
    input logic       cmd_valid,
    input logic [5:0] cmd_addr,
    input logic       wr_valid
);
    // R5: the command strobe lasts one cycle
    a_r5_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R5: a command and write data are never presented together
    a_r5_cmd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wr_valid));
    // R5: the address only moves with a command strobe
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> $stable(cmd_addr));
    // R6: the write data strobe lasts one cycle
    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);
    // R2: nothing happens before a bit period is known
    a_r2_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_locked |-> (!cmd_valid && !wr_valid && txd));
    // R2: once known, the bit period is kept
    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        baud_locked |=> baud_locked);
endmodule

bind sdbg_port sdbg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .baud_locked(baud_locked),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .wr_valid(wr_valid)
);

// File: tb/sdbg_port_bench.sv
`timescale 1ns/1ps
module sdbg_port_bench;
    localparam int P   = 16;  // learned bit period (cycles)
    localparam int PF  = 12;  // fixed bit period: FIXED_DIV = 11

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;     // 250 MHz

    logic        rxd = 1'b1, rxd_f = 1'b1;
    logic [15:0] rd_data = '0;
    logic        txd, baud_locked, cmd_valid, cmd_write, cmd_byte, wr_valid;
    logic [5:0]  cmd_addr;
    logic [15:0] wr_data;
    logic        txd_f, locked_f, cmdv_f, cmdw_f, cmdb_f, wrv_f;
    logic [5:0]  addr_f;
    logic [15:0] wrd_f;

    sdbg_port u_sdbg_port (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .baud_locked(baud_locked),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_byte(cmd_byte),
        .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_data(wr_data), .rd_data(rd_data)
    );

    sdbg_port #(.AUTO_SYNC(1'b0), .FIXED_DIV(PF-1), .SYNC_STAGES(0)) u_sdbg_port_fix (
        .clk(clk), .rst_n(rst_n), .rxd(rxd_f), .txd(txd_f), .baud_locked(locked_f),
        .cmd_valid(cmdv_f), .cmd_write(cmdw_f), .cmd_byte(cmdb_f),
        .cmd_addr(addr_f), .wr_valid(wrv_f), .wr_data(wrd_f), .rd_data(16'h0000)
    );

    int checks = 0, errors = 0;
    int ncmd = 0, nwr = 0, ncmd_f = 0, nwr_f = 0;
    logic       l_w, l_b;
    logic [5:0] l_a;
    logic [15:0] l_d, l_df;

    always @(negedge clk) begin
        if (cmd_valid) begin ncmd++; l_w = cmd_write; l_b = cmd_byte; l_a = cmd_addr; end
        if (wr_valid)  begin nwr++; l_d = wr_data; end
        if (cmdv_f)    ncmd_f++;
        if (wrv_f)     begin nwr_f++; l_df = wrd_f; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input bit fix, input logic [7:0] b, input bit stop_ok);
        int per = fix ? PF : P;
        logic [9:0] f = {stop_ok, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fix) rxd_f = f[i]; else rxd = f[i];
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk);
        if (fix) rxd_f = 1'b1; else rxd = 1'b1;
        if (!stop_ok) repeat (per) @(negedge clk);
    endtask

    task automatic recv(output logic [7:0] b, output bit ok);
        int t = 0;
        ok = 1'b0;
        b  = '0;
        while (txd && t < 40 * P) begin @(negedge clk); t++; end
        if (!txd) begin
            repeat (P / 2) @(negedge clk);
            ok = !txd;
            for (int i = 0; i < 8; i++) begin
                repeat (P) @(negedge clk);
                b[i] = txd;
            end
            repeat (P) @(negedge clk);
            ok = ok && txd;
        end
    endtask

    task automatic t_reset();
        chk(!cmd_valid && !wr_valid, "R1 strobes", {cmd_valid, wr_valid}, 0);
        chk(txd === 1'b1, "R1 txd idle", txd, 1);
        chk(baud_locked === 1'b0, "R1 unlocked", baud_locked, 0);
    endtask

    task automatic t_sync();
        send_frame(0, 8'h80, 1);
        repeat (4) @(negedge clk);
        chk(baud_locked === 1'b1, "R2 locked", baud_locked, 1);
        chk(ncmd == 0, "R2 no cmd from sync", ncmd, 0);
    endtask

    task automatic t_glitch();
        int c0 = ncmd;
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (3 * P) @(negedge clk);
        chk(ncmd == c0, "R12 glitch rejected", ncmd, c0);
    endtask

    task automatic t_write_word();
        int c0 = ncmd, w0 = nwr;
        send_frame(0, 8'h95, 1);           // write, word, addr 0x15
        chk(ncmd == c0 + 1, "R5 cmd within stop bit", ncmd, c0 + 1);
        chk({l_w, l_b, l_a} == 8'h95, "R5 header fields", {l_w, l_b, l_a}, 8'h95);
        send_frame(0, 8'hEF, 1);
        chk(nwr == w0, "R6 no strobe after first byte", nwr, w0);
        send_frame(0, 8'hBE, 1);
        chk(nwr == w0 + 1, "R6 one strobe", nwr, w0 + 1);
        chk(l_d == 16'hBEEF, "R4 R6 word data", l_d, 16'hBEEF);
    endtask

    task automatic t_write_byte();
        int w0 = nwr;
        send_frame(0, 8'hE3, 1);           // write, byte, addr 0x23
        chk({l_w, l_b, l_a} == 8'hE3, "R5 byte header", {l_w, l_b, l_a}, 8'hE3);
        send_frame(0, 8'h3C, 1);
        chk(nwr == w0 + 1, "R7 one strobe", nwr, w0 + 1);
        chk(l_d == 16'h003C, "R7 byte data", l_d, 16'h003C);
    endtask

    task automatic t_read_word();
        logic [7:0] b0, b1;
        bit ok0, ok1;
        rd_data = 16'hA55A;
        fork
            send_frame(0, 8'h07, 1);       // read, word, addr 0x07
            recv(b0, ok0);
        join
        recv(b1, ok1);
        chk(ok0 && b0 == 8'h5A, "R8 low byte", b0, 8'h5A);
        chk(ok1 && b1 == 8'hA5, "R8 high byte", b1, 8'hA5);
        chk(l_a == 6'h07 && !l_w, "R5 read header", l_a, 6'h07);
    endtask

    task automatic t_read_byte();
        logic [7:0] b0;
        bit ok0, extra = 1'b0;
        rd_data = 16'h1234;
        fork
            send_frame(0, 8'h7E, 1);       // read, byte, addr 0x3E
            recv(b0, ok0);
        join
        chk(ok0 && b0 == 8'h34, "R9 byte", b0, 8'h34);
        repeat (25 * P) begin @(negedge clk); if (!txd) extra = 1'b1; end
        chk(!extra, "R9 no second byte", extra, 0);
    endtask

    task automatic t_frame_err();
        int c0 = ncmd, w0 = nwr;
        send_frame(0, 8'h95, 0);
        chk(ncmd == c0, "R10 bad frame dropped", ncmd, c0);
        send_frame(0, 8'hC1, 1);           // write, byte, addr 1
        send_frame(0, 8'h5D, 1);
        chk(ncmd == c0 + 1 && l_a == 6'h01, "R10 next frame ok", l_a, 6'h01);
        chk(nwr == w0 + 1 && l_d == 16'h005D, "R10 data after error", l_d, 16'h005D);
    endtask

    task automatic t_fixed();
        chk(locked_f === 1'b1, "R3 locked at reset", locked_f, 1);
        send_frame(1, 8'hC5, 1);
        send_frame(1, 8'h77, 1);
        chk(ncmd_f == 1, "R3 R11 fixed cmd", ncmd_f, 1);
        chk(nwr_f == 1 && l_df == 16'h0077, "R3 R11 fixed data", l_df, 16'h0077);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_sync();
        t_glitch();
        t_write_word();
        t_write_byte();
        t_read_word();
        t_read_byte();
        t_frame_err();
        t_fixed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule